// File: doc/BRIEF.md
# Codec Host Interrupt Status Controller

This block gathers the service conditions of a video codec's compressed-data path and presents them to a host processor. It watches the FIFO fill level, the encode/decode direction, the field-end marker on the word at the FIFO head, host FIFO reads and writes, a statistics-update pulse and a link-layer error pulse. From these inputs it derives six condition flags. Each flag drives its own output pin and also appears, in the same state, as a bit of a readable status register.

The host uses a small register port to work with the block. Through it the host clears the sticky flags, selects which flags may raise the interrupt, sets the polarity of the interrupt line, and issues a soft reset. The interrupt line is registered. No data word passes through the block: every pin is a plain control or status level, and the host FIFO reads and writes are observed as single-cycle strobes with no back-pressure.

Top module: `codec_irq_ctrl`

## Requirements
- R1: The stop flag (status bit 0) is registered. One clock after the inputs, it reads 1 when the block is in encode mode (`enc_mode`=1) and the FIFO level is 0, or in decode mode and the level equals DEPTH. Otherwise it reads 0.
- R2: The service-request flag (bit 1) follows the FIFO every cycle. In encode mode it reads 1 when the level is at least SRQ_MARK. In decode mode it reads 1 when the free space (DEPTH minus the level) is at least SRQ_MARK. Writing 1 to bit 1 of the status register has no effect on it.
- R3: The FIFO error flag (bit 2) is sticky. It is set by a host read while the FIFO is empty in encode mode, or by a host write while the FIFO is full in decode mode. Writing 1 to status bit 2 clears it, but an error in the same cycle keeps it set.
- R4: The last-code flag (bit 3) reads 1 one clock after a cycle in which the block is in encode mode, the FIFO is not empty, the head word carries the field-end marker and no host read occurs. The host read that removes that word clears the flag at the same edge.
- R5: The statistics-ready flag (bit 4) is sticky. It is set by `stats_upd`, and writing 1 to status bit 4 clears it. An update in the same cycle as the clear keeps it set.
- R6: The link-error flag (bit 5) is sticky. It is set by `link_err`, and writing 1 to status bit 5 clears it.
- R7: Each dedicated flag output equals its bit in the status register (address 0). The mask register is at address 1 and the mode register at address 2. Address 3 reads 0.
- R8: The interrupt is active when any status bit that is also set in the mask register is 1. `irq_o` shows this one clock after the status or mask change. The mask resets to 0.
- R9: Mode bit 0 selects the polarity of the interrupt line: 0 is active-high, 1 is active-low. The bit resets to 0.
- R10: While `rst_n` is low, all flags, the mask, the polarity bit and `irq_o` are 0.
- R11: Writing the mode register with bit 1 set returns all registers to their reset values at that clock edge. Bit 1 reads back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_mode | input | 1 | 1 = encode (host drains the FIFO), 0 = decode (host fills it) |
| fifo_level | input | LVL_W | Words currently held in the FIFO |
| head_last | input | 1 | Field-end marker of the word at the FIFO head |
| host_rd | input | 1 | Host reads one FIFO word this cycle |
| host_wr | input | 1 | Host writes one FIFO word this cycle |
| stats_upd | input | 1 | Pulse: field statistics registers updated |
| link_err | input | 1 | Pulse: unrecoverable link-layer error |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| stop_o | output | 1 | FIFO stop flag |
| srq_o | output | 1 | FIFO service-request flag |
| err_o | output | 1 | FIFO error flag |
| lcode_o | output | 1 | Last-code flag |
| stats_o | output | 1 | Statistics-ready flag |
| link_o | output | 1 | Link-error flag |
| irq_o | output | 1 | Host interrupt line |

## Verification
The bench builds the block with DEPTH=8 and SRQ_MARK=3. With these values, the full and empty stop conditions and both service-request thresholds can be reached using small level values. It can then step through every boundary in a short vector table. It can also show the encode/decode meaning swap of the stop and service-request flags at levels 0, 3, 5 and 8.

// File: rtl/codec_irq_pkg.sv
package codec_irq_pkg;
  localparam int NSRC   = 6;
  localparam int B_STOP = 0;
  localparam int B_SRQ  = 1;
  localparam int B_ERR  = 2;
  localparam int B_LAST = 3;
  localparam int B_STAT = 4;
  localparam int B_LINK = 5;

  // Flags that hold until the host writes 1 to them
  localparam logic [NSRC-1:0] STICKY = 6'b110100;

  localparam int MODE_POL  = 0;
  localparam int MODE_SRST = 1;

  typedef enum logic [1:0] {
    RA_STATUS = 2'd0,
    RA_MASK   = 2'd1,
    RA_MODE   = 2'd2,
    RA_RSVD   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/irq_cond_gen.sv
module irq_cond_gen
  import codec_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SRQ_MARK = 4,
  parameter int LVL_W    = $clog2(DEPTH + 1)
) (
  input  logic             enc_mode,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic             head_last,
  input  logic             host_rd,
  input  logic             host_wr,
  input  logic             stats_upd,
  input  logic             link_err,
  output logic [NSRC-1:0]  lvl_flags,
  output logic [NSRC-1:0]  events
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] MARK     = LVL_W'(SRQ_MARK);

  logic             empty, full;
  logic [LVL_W-1:0] space;

  assign empty = (fifo_level == '0);
  assign full  = (fifo_level == FULL_LVL);
  assign space = FULL_LVL - fifo_level;

  always_comb begin
    lvl_flags         = '0;
    lvl_flags[B_STOP] = enc_mode ? empty : full;
    lvl_flags[B_SRQ]  = enc_mode ? (fifo_level >= MARK) : (space >= MARK);
    // next host read would return the field's final word
    lvl_flags[B_LAST] = enc_mode & ~empty & head_last & ~host_rd;

    events         = '0;
    events[B_ERR]  = (enc_mode & host_rd & empty) | (~enc_mode & host_wr & full);
    events[B_STAT] = stats_upd;
    events[B_LINK] = link_err;
  end
endmodule

// File: rtl/irq_status_regs.sv
module irq_status_regs
  import codec_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [NSRC-1:0] lvl_flags,
  input  logic [NSRC-1:0] events,
  input  logic [NSRC-1:0] clr,
  input  logic            mask_we,
  input  logic [NSRC-1:0] mask_wdata,
  input  logic            pol_we,
  input  logic            pol_wdata,
  output logic [NSRC-1:0] status_q,
  output logic [NSRC-1:0] mask_q,
  output logic            pol_q
);
  logic [NSRC-1:0] status_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    if (STICKY[i]) begin : g_sticky
      // a new event outranks a clear in the same cycle
      assign status_d[i] = events[i] | (status_q[i] & ~clr[i]);
    end else begin : g_level
      assign status_d[i] = lvl_flags[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
      pol_q    <= 1'b0;
    end else if (soft_rst) begin
      status_q <= '0;
      mask_q   <= '0;
      pol_q    <= 1'b0;
    end else begin
      status_q <= status_d;
      if (mask_we) mask_q <= mask_wdata;
      if (pol_we)  pol_q  <= pol_wdata;
    end
  end
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import codec_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic [NSRC-1:0] status,
  input  logic [NSRC-1:0] mask,
  input  logic            pol,
  output logic            irq_q
);
  logic active;

  assign active = |(status & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (soft_rst) irq_q <= 1'b0;
    else               irq_q <= active ^ pol;
  end
endmodule

// File: rtl/codec_irq_ctrl.sv
module codec_irq_ctrl
  import codec_irq_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int SRQ_MARK = 4,
  parameter int DATA_W   = 8,
  localparam int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_mode,
  input  logic [LVL_W-1:0]  fifo_level,
  input  logic              head_last,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic              stats_upd,
  input  logic              link_err,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              stop_o,
  output logic              srq_o,
  output logic              err_o,
  output logic              lcode_o,
  output logic              stats_o,
  output logic              link_o,
  output logic              irq_o
);
  logic [NSRC-1:0] lvl_flags, events, clr_w, status_w, mask_w;
  logic            pol_w, soft_rst_w, mask_we, pol_we, wr_status;
  logic            unused_wdata;

  assign unused_wdata = ^reg_wdata;

  assign wr_status  = reg_we && (reg_addr == RA_STATUS);
  assign clr_w      = wr_status ? (reg_wdata[NSRC-1:0] & STICKY) : '0;
  assign mask_we    = reg_we && (reg_addr == RA_MASK);
  assign soft_rst_w = reg_we && (reg_addr == RA_MODE) && reg_wdata[MODE_SRST];
  assign pol_we     = reg_we && (reg_addr == RA_MODE) && !reg_wdata[MODE_SRST];

  irq_cond_gen #(.DEPTH(DEPTH), .SRQ_MARK(SRQ_MARK), .LVL_W(LVL_W)) u_cond (
    .enc_mode  (enc_mode),
    .fifo_level(fifo_level),
    .head_last (head_last),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .stats_upd (stats_upd),
    .link_err  (link_err),
    .lvl_flags (lvl_flags),
    .events    (events)
  );

  irq_status_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst_w),
    .lvl_flags (lvl_flags),
    .events    (events),
    .clr       (clr_w),
    .mask_we   (mask_we),
    .mask_wdata(reg_wdata[NSRC-1:0]),
    .pol_we    (pol_we),
    .pol_wdata (reg_wdata[MODE_POL]),
    .status_q  (status_w),
    .mask_q    (mask_w),
    .pol_q     (pol_w)
  );

  irq_line_drv u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .soft_rst(soft_rst_w),
    .status  (status_w),
    .mask    (mask_w),
    .pol     (pol_w),
    .irq_q   (irq_o)
  );

  assign stop_o  = status_w[B_STOP];
  assign srq_o   = status_w[B_SRQ];
  assign err_o   = status_w[B_ERR];
  assign lcode_o = status_w[B_LAST];
  assign stats_o = status_w[B_STAT];
  assign link_o  = status_w[B_LINK];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_STATUS: reg_rdata[NSRC-1:0] = status_w;
      RA_MASK:   reg_rdata[NSRC-1:0] = mask_w;
      RA_MODE:   reg_rdata[MODE_POL] = pol_w;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/codec_irq_ctrl_chk.sv
module codec_irq_ctrl_chk
  import codec_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             enc_mode,
  input logic [LVL_W-1:0] fifo_level,
  input logic             host_rd,
  input logic             stats_upd,
  input logic             reg_we,
  input logic             soft_rst,
  input logic [NSRC-1:0]  status,
  input logic [NSRC-1:0]  mask,
  input logic             pol,
  input logic             irq_o
);
  // R1: stop flag tracks direction-dependent empty/full one clock later
  assert_stop_meaning_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> status[B_STOP] ==
      $past(enc_mode ? (fifo_level == '0) : (fifo_level == LVL_W'(DEPTH))));

  // R3: error flag holds while no register write happens
  assert_err_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_ERR] && !reg_we |=> status[B_ERR]);

  // R4: the read that takes the final word drops the last-code flag
  assert_lcode_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    status[B_LAST] && host_rd |=> !status[B_LAST]);

  // R5: a statistics update always leaves the flag set
  assert_stats_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stats_upd && !soft_rst |=> status[B_STAT]);

  // R8 / R9: interrupt line reflects masked status and polarity a clock later
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !soft_rst |=> irq_o == $past((|(status & mask)) ^ pol));

  // R11: soft reset clears mask and polarity
  assert_soft_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (mask == '0) && !pol && !irq_o);
endmodule

bind codec_irq_ctrl codec_irq_ctrl_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enc_mode  (enc_mode),
  .fifo_level(fifo_level),
  .host_rd   (host_rd),
  .stats_upd (stats_upd),
  .reg_we    (reg_we),
  .soft_rst  (soft_rst_w),
  .status    (status_w),
  .mask      (mask_w),
  .pol       (pol_w),
  .irq_o     (irq_o)
);

// File: tb/codec_irq_ctrl_test.sv
`timescale 1ns/1ps
module codec_irq_ctrl_test;
  localparam int DEPTH  = 8;
  localparam int MARK   = 3;
  localparam int DATA_W = 8;
  localparam int LVL_W  = $clog2(DEPTH + 1);
  localparam int NVEC   = 15;

  // {enc, level[3:0], head_last, rd, wr, stats, link, expected status[5:0]}
  // status bits: 5 link, 4 stats, 3 lcode, 2 err, 1 srq, 0 stop
  localparam logic [15:0] VEC [NVEC] = '{
    {1'b1, 4'd0, 5'b00000, 6'b000001},  // R1 encode empty
    {1'b1, 4'd2, 5'b00000, 6'b000000},  // R2 below mark
    {1'b1, 4'd3, 5'b00000, 6'b000010},  // R2 at mark
    {1'b1, 4'd3, 5'b10000, 6'b001010},  // R4 head marked
    {1'b1, 4'd3, 5'b11000, 6'b000010},  // R4 read clears
    {1'b1, 4'd0, 5'b01000, 6'b000101},  // R3 underflow
    {1'b1, 4'd5, 5'b00000, 6'b000110},  // R3 sticky
    {1'b0, 4'd8, 5'b00000, 6'b000101},  // R1 decode full
    {1'b0, 4'd8, 5'b00100, 6'b000101},  // R3 overflow
    {1'b0, 4'd5, 5'b00000, 6'b000110},  // R2 decode space at mark
    {1'b0, 4'd0, 5'b10000, 6'b000110},  // R4 no lcode in decode, R1 empty no stop
    {1'b0, 4'd2, 5'b00010, 6'b010110},  // R5 stats
    {1'b0, 4'd2, 5'b00001, 6'b110110},  // R6 link
    {1'b1, 4'd1, 5'b10000, 6'b111100},  // R4 single word marked
    {1'b0, 4'd7, 5'b01000, 6'b110100}   // R2 space below mark
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enc_mode = 1'b0;
  logic [LVL_W-1:0]  fifo_level = '0;
  logic              head_last = 1'b0, host_rd = 1'b0, host_wr = 1'b0;
  logic              stats_upd = 1'b0, link_err = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic              reg_we = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic              stop_o, srq_o, err_o, lcode_o, stats_o, link_o, irq_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  codec_irq_ctrl #(.DEPTH(DEPTH), .SRQ_MARK(MARK), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .enc_mode(enc_mode), .fifo_level(fifo_level),
    .head_last(head_last), .host_rd(host_rd), .host_wr(host_wr),
    .stats_upd(stats_upd), .link_err(link_err), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stop_o(stop_o), .srq_o(srq_o), .err_o(err_o), .lcode_o(lcode_o),
    .stats_o(stats_o), .link_o(link_o), .irq_o(irq_o)
  );

  function automatic logic [5:0] flags();
    return {link_o, stats_o, lcode_o, err_o, srq_o, stop_o};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [DATA_W-1:0] d);
    reg_addr  = a;
    reg_wdata = d;
    reg_we    = 1'b1;
    tick();
    reg_we    = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] a, output logic [DATA_W-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_in(input logic e, input int l, input logic [4:0] p);
    enc_mode   = e;
    fifo_level = LVL_W'(l);
    {head_last, host_rd, host_wr, stats_upd, link_err} = p;
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual 0x0 expected 0x1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] rd;
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state
    check("R10 flags in reset", int'(flags()), 0);
    check("R10 irq in reset", int'(irq_o), 0);
    rst_n = 1'b1;
    reg_read(2'd1, rd);
    check("R8 mask reset", int'(rd), 0);
    reg_read(2'd2, rd);
    check("R9 mode reset", int'(rd), 0);
    reg_addr = 2'd0;

    for (int i = 0; i < NVEC; i++) begin
      set_in(VEC[i][15], int'(VEC[i][14:11]), VEC[i][10:6]);
      tick();
      check($sformatf("R1-table vec %0d flags", i), int'(flags()), int'(VEC[i][5:0]));
      reg_read(2'd0, rd);
      check($sformatf("R7 vec %0d status mirror", i), int'(rd), int'(flags()));
      check($sformatf("R8 vec %0d irq masked off", i), int'(irq_o), 0);
    end
    reg_read(2'd3, rd);
    check("R7 reserved reads zero", int'(rd), 0);

    // R3 R5 R6 clear; R2 srq unaffected by write
    set_in(1'b0, 5, 5'b00000);
    tick();
    check("R2 setup", int'(flags()), 6'b110110);
    reg_write(2'd0, 8'h3F);
    check("R2 R3 R5 R6 write-one-clear", int'(flags()), 6'b000010);

    // R3 R5: set wins over clear
    set_in(1'b1, 0, 5'b01010);
    reg_write(2'd0, 8'h14);
    check("R3 R5 set beats clear", int'(flags()), 6'b010101);
    set_in(1'b1, 0, 5'b00000);
    reg_write(2'd0, 8'h14);
    check("R3 R5 clear", int'(flags()), 6'b000001);

    // R8: mask timing
    reg_write(2'd1, 8'h01);
    check("R8 irq one clock after mask", int'(irq_o), 0);
    tick();
    check("R8 irq raised", int'(irq_o), 1);
    reg_write(2'd1, 8'h02);
    check("R8 irq still old", int'(irq_o), 1);
    tick();
    check("R8 unmasked source drops irq", int'(irq_o), 0);
    reg_read(2'd1, rd);
    check("R8 mask readback", int'(rd), 8'h02);

    // R9: polarity
    reg_write(2'd1, 8'h01);
    tick();
    check("R9 active-high", int'(irq_o), 1);
    reg_write(2'd2, 8'h01);
    tick();
    check("R9 active-low asserted", int'(irq_o), 0);
    set_in(1'b1, 3, 5'b00000);
    tick();
    tick();
    check("R9 active-low idle", int'(irq_o), 1);
    reg_read(2'd2, rd);
    check("R9 mode readback", int'(rd), 1);

    // R11: soft reset
    set_in(1'b1, 0, 5'b00010);
    tick();
    set_in(1'b1, 0, 5'b00000);
    reg_write(2'd2, 8'h02);
    check("R11 flags cleared", int'(flags()), 0);
    check("R11 irq cleared", int'(irq_o), 0);
    reg_read(2'd1, rd);
    check("R11 mask cleared", int'(rd), 0);
    reg_read(2'd2, rd);
    check("R11 mode cleared", int'(rd), 0);

    // R10: asynchronous reset mid-run
    set_in(1'b1, 0, 5'b00010);
    tick();
    set_in(1'b1, 0, 5'b00000);
    reg_write(2'd1, 8'h10);
    tick();
    check("R10 irq before reset", int'(irq_o), 1);
    rst_n = 1'b0;
    #0.5;
    check("R10 async flags", int'(flags()), 0);
    check("R10 async irq", int'(irq_o), 0);
    reg_read(2'd1, rd);
    check("R10 async mask", int'(rd), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule